// File: doc/BRIEF.md
# Serial Debug Port Shift Interface

This block is the serial side of a processor's debug port. A single 35-bit shift register takes frames from a debug host one bit at a time, most significant bit first. Each frame holds a two-bit kind field in bits 34:33, an ignored bit 32 and a 32-bit payload in bits 31:0. When a frame is complete, the kind field decides where the payload goes. It can become the next instruction the core fetches while halted, a word the core reads as debug data, or the new value of the trap-enable control register. The core can also write a word into the port. That word is parallel-loaded into the same shift register at the next frame boundary and clocked out on the serial output while the host shifts in its following frame.

The shift clock is chosen by a mode input. In system-clock mode, one bit is taken on every system clock cycle in which the serial clock pin is high. In external mode, the serial clock and data pins pass through synchronizers, and a bit is taken on each detected rising edge. The block registers a freeze output and a two-bit status code from the core's debug-mode signal. Every outgoing frame carries freeze and data-valid flags in its leading bits. The core side uses request/acknowledge handshakes.

Top module: `dbgp_serial_port`

## Requirements
- R1: A frame is 35 bits, shifted in MSB first. Bits 34:33 select the kind (00 instruction, 01 data, 10 trap-enable write, 11 no operation), bit 32 is ignored and bits 31:0 are the payload.
- R2: With `clk_mode_ext`=0, one bit is shifted on each rising `clk` edge at which `ser_clk` is high. With `clk_mode_ext`=1, `ser_clk` and `ser_din` pass through a two-stage synchronizer, and one bit is shifted per synchronized rising edge of `ser_clk`.
- R3: An instruction frame is held until fetched. `ifetch_ack` pulses for one cycle with `ifetch_data` equal to the payload, and only while `frz` is high. A fetch request made outside freeze is held off until freeze begins.
- R4: A data frame is held until the core raises `drd_req`. `drd_ack` then pulses for one cycle with `drd_data` equal to the payload.
- R5: A trap-enable frame loads `trap_en` with the full 32-bit payload.
- R6: A kind-11 frame has no effect. `trap_en` is unchanged, and neither a fetch nor a read is acknowledged afterwards.
- R7: A core write (`dwr_req`, `dwr_data`) is acknowledged with a one-cycle `dwr_ack` pulse. Its data appears as bits 31:0 of the next outgoing frame that is loaded after the write, with bit 33 set. The frame after that has bit 33 clear and a zero payload.
- R8: An outgoing frame is loaded when the previous incoming frame completes. Bit 34 is `frz` at load time, bit 33 is data-valid and bit 32 is 0. The first frame after reset, and the first frame after a discard, shift out all zeros.
- R9: `frz` equals `debug_mode` delayed by one clock. `vfls` is 2'b11 while frozen and 2'b00 otherwise, with the same delay.
- R10: A change of `clk_mode_ext` discards any partial frame. The next 35 bits form a fresh frame.
- R11: After reset, `frz`, `vfls`, `ser_dout`, `trap_en` and all acknowledges are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_mode_ext | input | 1 | 1: external serial clock, 0: system clock shifting |
| ser_clk | input | 1 | Serial clock (external mode) or shift enable (system mode) |
| ser_din | input | 1 | Serial data in, MSB first |
| ser_dout | output | 1 | Serial data out, MSB first |
| debug_mode | input | 1 | Core is halted in debug mode |
| frz | output | 1 | Registered freeze indication |
| vfls | output | 2 | Status code, 11 while frozen |
| ifetch_req | input | 1 | Core requests the next debug instruction |
| ifetch_ack | output | 1 | Instruction delivered (one-cycle pulse) |
| ifetch_data | output | 32 | Delivered instruction |
| drd_req | input | 1 | Core reads the debug data register |
| drd_ack | output | 1 | Read data delivered (one-cycle pulse) |
| drd_data | output | 32 | Delivered data |
| dwr_req | input | 1 | Core writes the debug data register |
| dwr_data | input | 32 | Data to send to the host |
| dwr_ack | output | 1 | Write accepted (one-cycle pulse) |
| trap_en | output | 32 | Trap-enable control register |

## Verification
The hardest situation to reach is a partial frame interrupted by a clock-mode switch. The discard has to empty the shift register while keeping a pending core write, so that the write reaches the host one frame later than it otherwise would. The stimulus gets there in two steps. Directed sequences shift 20 bits and then toggle the mode, with and without a write pending. A seeded random loop then mixes mode switches, frame kinds and core writes. Every outgoing frame is compared with a bench model of what the port should have loaded.

// File: rtl/dbgp_pkg.sv
package dbgp_pkg;
  localparam int KIND_W = 2;
  localparam int STAT_W = 3;

  typedef enum logic [KIND_W-1:0] {
    FK_INSTR = 2'b00,
    FK_DATA  = 2'b01,
    FK_TRAP  = 2'b10,
    FK_NOP   = 2'b11
  } frame_kind_e;
endpackage

// File: rtl/dbgp_clk_sel.sv
module dbgp_clk_sel #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_ext,
  input  logic ser_clk,
  input  logic ser_din,
  output logic tick,
  output logic bit_o,
  output logic discard
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] ck_s;
  logic [SYNC_STAGES-1:0] dt_s;
  logic                   ck_prev;
  logic                   mode_q;
  logic                   ext_tick;

  // synchronizer chains for clock and data pins, plus edge history
  always_ff @(posedge clk) begin
    if (rst) begin
      ck_s    <= '0;
      dt_s    <= '0;
      ck_prev <= 1'b0;
      mode_q  <= mode_ext;
    end else begin
      ck_s[0] <= ser_clk;
      dt_s[0] <= ser_din;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        ck_s[i] <= ck_s[i-1];
        dt_s[i] <= dt_s[i-1];
      end
      ck_prev <= ck_s[TOP];
      mode_q  <= mode_ext;
    end
  end

  assign ext_tick = ck_s[TOP] & ~ck_prev;
  assign discard  = (mode_ext != mode_q);

  always_comb begin
    if (discard) begin
      tick  = 1'b0;
      bit_o = 1'b0;
    end else if (mode_q) begin
      tick  = ext_tick;
      bit_o = dt_s[TOP];
    end else begin
      tick  = ser_clk;
      bit_o = ser_din;
    end
  end
endmodule

// File: rtl/dbgp_shift.sv
module dbgp_shift #(
  parameter int FRAME_W = 35
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               bit_i,
  input  logic               discard,
  input  logic [FRAME_W-1:0] load_word,
  output logic               ser_dout,
  output logic               load_o,
  output logic               rx_valid,
  output logic [FRAME_W-1:0] rx_word
);
  localparam int             CNT_W = $clog2(FRAME_W + 1);
  localparam [CNT_W-1:0]     LAST  = CNT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] sreg;
  logic [CNT_W-1:0]   cnt;
  logic               last;

  assign last     = (cnt == LAST);
  assign load_o   = tick & last & ~discard;
  assign ser_dout = sreg[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg     <= '0;
      cnt      <= '0;
      rx_valid <= 1'b0;
      rx_word  <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (discard) begin
        sreg <= '0;
        cnt  <= '0;
      end else if (tick) begin
        if (last) begin
          cnt      <= '0;
          rx_valid <= 1'b1;
          rx_word  <= {sreg[FRAME_W-2:0], bit_i};
          sreg     <= load_word;
        end else begin
          cnt  <= cnt + 1'b1;
          sreg <= {sreg[FRAME_W-2:0], bit_i};
        end
      end
    end
  end
endmodule

// File: rtl/dbgp_core_if.sv
module dbgp_core_if
  import dbgp_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int FRAME_W = DATA_W + STAT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rx_valid,
  input  logic [FRAME_W-1:0] rx_word,
  input  logic               load,
  input  logic               debug_mode,
  output logic               frz,
  output logic [1:0]         vfls,
  input  logic               ifetch_req,
  output logic               ifetch_ack,
  output logic [DATA_W-1:0]  ifetch_data,
  input  logic               drd_req,
  output logic               drd_ack,
  output logic [DATA_W-1:0]  drd_data,
  input  logic               dwr_req,
  input  logic [DATA_W-1:0]  dwr_data,
  output logic               dwr_ack,
  output logic [DATA_W-1:0]  trap_en,
  output logic [FRAME_W-1:0] load_word
);
  localparam int PAD_W = FRAME_W - DATA_W - 2;

  frame_kind_e       kind;
  logic [DATA_W-1:0] payload;
  logic [DATA_W-1:0] instr_buf, rd_buf, out_buf;
  logic              instr_pend, rd_pend, out_pend;

  assign kind    = frame_kind_e'(rx_word[FRAME_W-1 -: KIND_W]);
  assign payload = rx_word[DATA_W-1:0];

  assign load_word = {frz, out_pend, {PAD_W{1'b0}},
                      (out_pend ? out_buf : {DATA_W{1'b0}})};

  always_ff @(posedge clk) begin
    if (rst) begin
      frz         <= 1'b0;
      vfls        <= 2'b00;
      ifetch_ack  <= 1'b0;
      ifetch_data <= '0;
      drd_ack     <= 1'b0;
      drd_data    <= '0;
      dwr_ack     <= 1'b0;
      trap_en     <= '0;
      instr_buf   <= '0;
      rd_buf      <= '0;
      out_buf     <= '0;
      instr_pend  <= 1'b0;
      rd_pend     <= 1'b0;
      out_pend    <= 1'b0;
    end else begin
      frz        <= debug_mode;
      vfls       <= debug_mode ? 2'b11 : 2'b00;
      ifetch_ack <= 1'b0;
      drd_ack    <= 1'b0;
      dwr_ack    <= 1'b0;

      // instruction fetch, served only while halted
      if (ifetch_req && instr_pend && frz && !ifetch_ack) begin
        ifetch_ack  <= 1'b1;
        ifetch_data <= instr_buf;
        instr_pend  <= 1'b0;
      end

      // debug data read
      if (drd_req && rd_pend && !drd_ack) begin
        drd_ack  <= 1'b1;
        drd_data <= rd_buf;
        rd_pend  <= 1'b0;
      end

      // debug data write: held until the next frame boundary
      if (dwr_req && !out_pend && !dwr_ack) begin
        dwr_ack  <= 1'b1;
        out_buf  <= dwr_data;
        out_pend <= 1'b1;
      end else if (load && out_pend) begin
        out_pend <= 1'b0;
      end

      // completed frame dispatch; a new arrival wins over a same-cycle consume
      if (rx_valid) begin
        unique case (kind)
          FK_INSTR: begin
            instr_buf  <= payload;
            instr_pend <= 1'b1;
          end
          FK_DATA: begin
            rd_buf  <= payload;
            rd_pend <= 1'b1;
          end
          FK_TRAP: trap_en <= payload;
          FK_NOP:  ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dbgp_serial_port.sv
module dbgp_serial_port #(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_mode_ext,
  input  logic              ser_clk,
  input  logic              ser_din,
  output logic              ser_dout,
  input  logic              debug_mode,
  output logic              frz,
  output logic [1:0]        vfls,
  input  logic              ifetch_req,
  output logic              ifetch_ack,
  output logic [DATA_W-1:0] ifetch_data,
  input  logic              drd_req,
  output logic              drd_ack,
  output logic [DATA_W-1:0] drd_data,
  input  logic              dwr_req,
  input  logic [DATA_W-1:0] dwr_data,
  output logic              dwr_ack,
  output logic [DATA_W-1:0] trap_en
);
  localparam int FRAME_W = DATA_W + dbgp_pkg::STAT_W;

  logic               tick, bit_s, discard, load;
  logic               rx_valid;
  logic [FRAME_W-1:0] rx_word, load_word;

  dbgp_clk_sel #(.SYNC_STAGES(SYNC_STAGES)) u_clk_sel (
    .clk      (clk),
    .rst      (rst),
    .mode_ext (clk_mode_ext),
    .ser_clk  (ser_clk),
    .ser_din  (ser_din),
    .tick     (tick),
    .bit_o    (bit_s),
    .discard  (discard)
  );

  dbgp_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .bit_i     (bit_s),
    .discard   (discard),
    .load_word (load_word),
    .ser_dout  (ser_dout),
    .load_o    (load),
    .rx_valid  (rx_valid),
    .rx_word   (rx_word)
  );

  dbgp_core_if #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_core_if (
    .clk         (clk),
    .rst         (rst),
    .rx_valid    (rx_valid),
    .rx_word     (rx_word),
    .load        (load),
    .debug_mode  (debug_mode),
    .frz         (frz),
    .vfls        (vfls),
    .ifetch_req  (ifetch_req),
    .ifetch_ack  (ifetch_ack),
    .ifetch_data (ifetch_data),
    .drd_req     (drd_req),
    .drd_ack     (drd_ack),
    .drd_data    (drd_data),
    .dwr_req     (dwr_req),
    .dwr_data    (dwr_data),
    .dwr_ack     (dwr_ack),
    .trap_en     (trap_en),
    .load_word   (load_word)
  );
endmodule

// File: rtl/dbgp_serial_port_chk.sv
module dbgp_serial_port_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              clk_mode_ext,
  input logic              ser_clk,
  input logic              ser_din,
  input logic              ser_dout,
  input logic              debug_mode,
  input logic              frz,
  input logic [1:0]        vfls,
  input logic              ifetch_req,
  input logic              ifetch_ack,
  input logic [DATA_W-1:0] ifetch_data,
  input logic              drd_req,
  input logic              drd_ack,
  input logic [DATA_W-1:0] drd_data,
  input logic              dwr_req,
  input logic [DATA_W-1:0] dwr_data,
  input logic              dwr_ack,
  input logic [DATA_W-1:0] trap_en
);
  a_r9_frz_follow: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (frz == $past(debug_mode)));

  a_r9_vfls_follow: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (vfls == {2{$past(debug_mode)}}));

  a_r3_fetch_frozen: assert property (@(posedge clk) disable iff (rst)
    ifetch_ack |-> $past(frz));

  a_r3_fetch_pulse: assert property (@(posedge clk) disable iff (rst)
    ifetch_ack |=> !ifetch_ack);

  a_r4_read_pulse: assert property (@(posedge clk) disable iff (rst)
    drd_ack |=> !drd_ack);

  a_r7_write_req: assert property (@(posedge clk) disable iff (rst)
    dwr_ack |-> $past(dwr_req));

  a_r7_write_pulse: assert property (@(posedge clk) disable iff (rst)
    dwr_ack |=> !dwr_ack);
endmodule

bind dbgp_serial_port dbgp_serial_port_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/dbgp_serial_port_tb.sv
module dbgp_serial_port_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clk_mode_ext = 1'b0;
  logic        ser_clk = 1'b0;
  logic        ser_din = 1'b0;
  logic        ser_dout;
  logic        debug_mode = 1'b0;
  logic        frz;
  logic [1:0]  vfls;
  logic        ifetch_req = 1'b0;
  logic        ifetch_ack;
  logic [31:0] ifetch_data;
  logic        drd_req = 1'b0;
  logic        drd_ack;
  logic [31:0] drd_data;
  logic        dwr_req = 1'b0;
  logic [31:0] dwr_data = '0;
  logic        dwr_ack;
  logic [31:0] trap_en;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // bench model
  logic [34:0] exp_out = '0;
  logic        m_pend  = 1'b0;
  logic [31:0] m_pdata = '0;
  logic [31:0] m_trap  = '0;
  logic [34:0] got;
  logic        ack_seen;
  logic [31:0] ack_val;

  always #5 clk = ~clk;

  dbgp_serial_port u_dut (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [34:0] mk(input logic [1:0] kind, input logic [31:0] p);
    return {kind, 1'b0, p};
  endfunction

  function automatic logic [34:0] next_out(input logic f, input logic pend, input logic [31:0] d);
    return {f, pend, 1'b0, (pend ? d : 32'h0)};
  endfunction

  // shift nbits of w (MSB first) and capture ser_dout into got
  task automatic shift_bits(input logic [34:0] w, input int nbits);
    got = '0;
    for (int i = 0; i < nbits; i++) begin
      if (!clk_mode_ext) begin
        @(negedge clk);
        got[34-i] = ser_dout;
        ser_din   = w[34-i];
        ser_clk   = 1'b1;
      end else begin
        @(negedge clk);
        ser_din = w[34-i];
        ser_clk = 1'b0;
        repeat (3) @(negedge clk);
        got[34-i] = ser_dout;
        ser_clk   = 1'b1;
        repeat (3) @(negedge clk);
      end
    end
    @(negedge clk);
    ser_clk = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  // complete frame plus model update and outgoing frame check
  task automatic frame(input logic [1:0] kind, input logic [31:0] p);
    shift_bits(mk(kind, p), 35);
    check("R8/R7 outgoing frame", {29'h0, got}, {29'h0, exp_out});
    exp_out = next_out(debug_mode, m_pend, m_pdata);
    m_pend  = 1'b0;
    if (kind == 2'b10) m_trap = p;
  endtask

  task automatic set_mode(input logic m);
    @(negedge clk);
    ser_clk      = 1'b0;
    clk_mode_ext = m;
    exp_out      = '0;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_fetch(input int limit);
    ack_seen = 1'b0;
    @(negedge clk);
    ifetch_req = 1'b1;
    for (int i = 0; i < limit && !ack_seen; i++) begin
      @(negedge clk);
      if (ifetch_ack) begin
        ack_seen = 1'b1;
        ack_val  = ifetch_data;
      end
    end
    ifetch_req = 1'b0;
  endtask

  task automatic do_read(input int limit);
    ack_seen = 1'b0;
    @(negedge clk);
    drd_req = 1'b1;
    for (int i = 0; i < limit && !ack_seen; i++) begin
      @(negedge clk);
      if (drd_ack) begin
        ack_seen = 1'b1;
        ack_val  = drd_data;
      end
    end
    drd_req = 1'b0;
  endtask

  task automatic do_write(input logic [31:0] d);
    ack_seen = 1'b0;
    @(negedge clk);
    dwr_req  = 1'b1;
    dwr_data = d;
    for (int i = 0; i < 20 && !ack_seen; i++) begin
      @(negedge clk);
      if (dwr_ack) ack_seen = 1'b1;
    end
    dwr_req = 1'b0;
    check("R7 write ack", {63'h0, ack_seen}, 64'h1);
    m_pend  = 1'b1;
    m_pdata = d;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check("R11 frz", {63'h0, frz}, 64'h0);
    check("R11 vfls", {62'h0, vfls}, 64'h0);
    check("R11 dout", {63'h0, ser_dout}, 64'h0);
    check("R11 trap_en", {32'h0, trap_en}, 64'h0);
    check("R11 acks", {61'h0, ifetch_ack, drd_ack, dwr_ack}, 64'h0);

    // R9 freeze and status
    debug_mode = 1'b1;
    @(negedge clk);
    check("R9 frz set", {63'h0, frz}, 64'h1);
    check("R9 vfls 11", {62'h0, vfls}, 64'h3);
    debug_mode = 1'b0;
    @(negedge clk);
    check("R9 vfls 00", {62'h0, vfls}, 64'h0);

    // R3 fetch held off outside freeze, then served
    frame(2'b00, 32'hCAFE_0001);
    do_fetch(12);
    check("R3 no fetch unfrozen", {63'h0, ack_seen}, 64'h0);
    debug_mode = 1'b1;
    repeat (2) @(negedge clk);
    do_fetch(12);
    check("R3 fetch ack", {63'h0, ack_seen}, 64'h1);
    check("R3 fetch data", {32'h0, ack_val}, {32'h0, 32'hCAFE_0001});

    // R5 / R1 trap write; bit 32 set in the frame must be ignored
    shift_bits({2'b10, 1'b1, 32'h1234_5678}, 35);
    check("R8 outgoing frame", {29'h0, got}, {29'h0, exp_out});
    exp_out = next_out(1'b1, m_pend, m_pdata);
    m_trap  = 32'h1234_5678;
    check("R5 trap_en", {32'h0, trap_en}, {32'h0, m_trap});

    // R4 data read
    frame(2'b01, 32'hA5A5_0F0F);
    do_read(12);
    check("R4 read ack", {63'h0, ack_seen}, 64'h1);
    check("R4 read data", {32'h0, ack_val}, {32'h0, 32'hA5A5_0F0F});

    // R7 core write out through the next frames (checked inside frame)
    do_write(32'hDEAD_BEEF);
    frame(2'b11, 32'h0);
    frame(2'b11, 32'h0);
    check("R7 valid cleared", {63'h0, exp_out[33]}, 64'h0);

    // R6 nop frame has no effect
    frame(2'b11, 32'hFFFF_FFFF);
    check("R6 trap unchanged", {32'h0, trap_en}, {32'h0, m_trap});
    do_read(10);
    check("R6 no read ack", {63'h0, ack_seen}, 64'h0);
    do_fetch(10);
    check("R6 no fetch ack", {63'h0, ack_seen}, 64'h0);

    // R2 external clock mode
    set_mode(1'b1);
    frame(2'b10, 32'h0BAD_F00D);
    check("R2 ext trap", {32'h0, trap_en}, {32'h0, 32'h0BAD_F00D});

    // R10 partial frame then mode change, with a write pending
    do_write(32'h5555_AAAA);
    shift_bits(mk(2'b10, 32'hFFFF_0000), 20);
    set_mode(1'b0);
    frame(2'b10, 32'h1357_9BDF);
    check("R10 fresh frame", {32'h0, trap_en}, {32'h0, 32'h1357_9BDF});
    frame(2'b11, 32'h0);
    shift_bits(mk(2'b01, 32'h0), 20);
    set_mode(1'b1);
    frame(2'b10, 32'h2468_ACE0);
    check("R10 ext fresh", {32'h0, trap_en}, {32'h0, 32'h2468_ACE0});
    do_read(10);
    check("R10 discarded data", {63'h0, ack_seen}, 64'h0);

    // random mix
    for (int n = 0; n < 24; n++) begin
      logic [1:0]  k;
      logic [31:0] p;
      k = 2'($urandom_range(0, 3));
      p = $urandom;
      if ($urandom_range(0, 4) == 0) set_mode(~clk_mode_ext);
      if (!m_pend && $urandom_range(0, 2) == 0) do_write($urandom);
      frame(k, p);
      case (k)
        2'b00: begin
          do_fetch(10);
          check("R3 rand fetch", {31'h0, ack_seen, ack_val}, {31'h0, 1'b1, p});
        end
        2'b01: begin
          do_read(10);
          check("R4 rand read", {31'h0, ack_seen, ack_val}, {31'h0, 1'b1, p});
        end
        default: check("R5 rand trap", {32'h0, trap_en}, {32'h0, m_trap});
      endcase
    end

    finish_run();
  end
endmodule